// File: doc/BRIEF.md
# Decode-Stage Hazard and Stall Unit

This combinational unit sits beside the decode stage of an in-order five-stage pipeline. Each cycle it looks at the source registers of the instruction in decode and at what the two instructions ahead of it will write. From that it decides whether the pipeline must hold for a cycle. On a hold, the program counter and the fetch/decode register keep their values, so the same instruction is decoded again and the next one is fetched again. At the same time the control fields going into the decode/execute register are forced to zero, which sends a bubble down the pipeline.

The unit handles two kinds of hazard. The first is the ordinary load-use case: a load is in execute and a later instruction needs its result. The second comes from branches, which compare registers and resolve in decode, so they need their operands earlier than an ALU instruction does. A branch waits one cycle behind an ALU instruction that writes one of its compare registers, and one cycle behind such a load while that load is in the memory stage. A branch right after a dependent load therefore waits two cycles in total. Register 0 is never treated as a dependence.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the execute-stage instruction is a load (exMemRead=1) and its destination exDest is nonzero and equals idRs or idRt, ctrlZero is 1, whatever the value of idIsBranch.
- R2: When idIsBranch=1 and the execute-stage instruction writes a register (exRegWrite=1, exMemRead=0) whose nonzero number equals idRs or idRt, ctrlZero is 1.
- R3: When idIsBranch=1 and the memory-stage instruction is a load (memMemRead=1) whose nonzero destination memDest equals idRs or idRt, ctrlZero is 1.
- R4: A non-branch instruction in decode does not stall for a load in the memory stage, even if memDest matches one of its sources.
- R5: A branch does not stall for an ALU result two or more instructions earlier.
- R6: A destination number of 0 never causes a stall.
- R7: pcWriteEn and ifIdWriteEn are both the inverse of ctrlZero in every cycle.
- R8: A non-branch instruction does not stall behind a dependent ALU instruction in execute. With nothing in flight, the unit does not stall.
- R9: In a stepped pipeline, a load followed by a dependent instruction costs exactly one stall cycle. A branch right after a dependent load costs exactly two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | REG_W | First source register of the instruction in decode |
| idRt | input | REG_W | Second source register of the instruction in decode |
| idIsBranch | input | 1 | Instruction in decode is a register-compare branch |
| exMemRead | input | 1 | Instruction in execute is a load |
| exRegWrite | input | 1 | Instruction in execute writes a register |
| exDest | input | REG_W | Destination register of the instruction in execute |
| memMemRead | input | 1 | Instruction in memory stage is a load |
| memDest | input | REG_W | Destination register of the instruction in memory stage |
| pcWriteEn | output | 1 | Program counter may advance |
| ifIdWriteEn | output | 1 | Fetch/decode register may load |
| ctrlZero | output | 1 | Zero the control fields entering decode/execute |

## Verification
The bench builds the unit with the default REG_W of 5, which gives 32 registers, including register 0. Short instruction sequences are fed through a cycle-stepped pipeline model driven by the unit's own outputs. This lets the bench count the exact number of stall cycles a chosen instruction spends in decode, including the two-cycle wait of a branch behind a load. The sequences also cover the cases that must not stall: forwarding distance, non-branch consumers, and register 0.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef struct packed {
    logic loadUse;
    logic brAfterAlu;
    logic brAfterLoad;
  } hazStrobes_t;
endpackage

// File: rtl/hazard_detect.sv
module hazard_detect
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idIsBranch,
  input  logic             exMemRead,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] exDest,
  input  logic             memMemRead,
  input  logic [REG_W-1:0] memDest,
  output hazStrobes_t      strobes
);
  localparam logic [REG_W-1:0] ZeroReg = '0;

  logic exHit;
  logic memHit;

  always_comb begin
    exHit  = (exDest != ZeroReg) && ((exDest == idRs) || (exDest == idRt));
    memHit = (memDest != ZeroReg) && ((memDest == idRs) || (memDest == idRt));
    strobes.loadUse     = exMemRead && exHit;
    strobes.brAfterAlu  = idIsBranch && exRegWrite && !exMemRead && exHit;
    strobes.brAfterLoad = idIsBranch && memMemRead && memHit;
  end

  always_comb begin
    if (!idIsBranch) begin
      AST_PLAIN_NO_BRANCH_STROBES: assert (!strobes.brAfterAlu && !strobes.brAfterLoad)
        else $error("branch strobe without branch"); // R4
    end
  end
endmodule

// File: rtl/stall_gate.sv
module stall_gate
  import hazard_pkg::*;
(
  input  hazStrobes_t strobes,
  output logic        pcWriteEn,
  output logic        ifIdWriteEn,
  output logic        ctrlZero
);
  logic stall;

  always_comb begin
    stall       = strobes.loadUse | strobes.brAfterAlu | strobes.brAfterLoad;
    ctrlZero    = stall;
    pcWriteEn   = !stall;
    ifIdWriteEn = !stall;
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idIsBranch,
  input  logic             exMemRead,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] exDest,
  input  logic             memMemRead,
  input  logic [REG_W-1:0] memDest,
  output logic             pcWriteEn,
  output logic             ifIdWriteEn,
  output logic             ctrlZero
);
  hazStrobes_t strobes;

  hazard_detect #(.REG_W(REG_W)) i_detect (
    .idRs(idRs), .idRt(idRt), .idIsBranch(idIsBranch),
    .exMemRead(exMemRead), .exRegWrite(exRegWrite), .exDest(exDest),
    .memMemRead(memMemRead), .memDest(memDest), .strobes(strobes)
  );

  stall_gate i_gate (
    .strobes(strobes), .pcWriteEn(pcWriteEn),
    .ifIdWriteEn(ifIdWriteEn), .ctrlZero(ctrlZero)
  );

  always_comb begin
    AST_ENABLES_AGREE: assert (pcWriteEn == ifIdWriteEn && pcWriteEn == !ctrlZero)
      else $error("enable mismatch"); // R7
    if (exDest == '0 && memDest == '0) begin
      AST_ZERO_DEST_QUIET: assert (!ctrlZero) else $error("stall on r0"); // R6
    end
    if (exMemRead && exDest != '0 && exDest == idRs) begin
      AST_LOAD_USE_HOLDS: assert (ctrlZero) else $error("missed load-use"); // R1
    end
    if (!idIsBranch && !exMemRead) begin
      AST_PLAIN_NO_STALL: assert (!ctrlZero) else $error("spurious stall"); // R8
    end
  end
endmodule

// File: tb/test_hazard_stall_unit.sv
module test_hazard_stall_unit;
  localparam int REG_W = 5;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0] idRs, idRt, exDest, memDest;
  logic idIsBranch, exMemRead, exRegWrite, memMemRead;
  logic pcWriteEn, ifIdWriteEn, ctrlZero;

  hazard_stall_unit #(.REG_W(REG_W)) i_hazard_stall_unit (
    .idRs(idRs), .idRt(idRt), .idIsBranch(idIsBranch),
    .exMemRead(exMemRead), .exRegWrite(exRegWrite), .exDest(exDest),
    .memMemRead(memMemRead), .memDest(memDest),
    .pcWriteEn(pcWriteEn), .ifIdWriteEn(ifIdWriteEn), .ctrlZero(ctrlZero)
  );

  int errors = 0;
  int checks = 0;

  logic             pLoad [MAXP];
  logic             pWr   [MAXP];
  logic             pBr   [MAXP];
  logic [REG_W-1:0] pDst  [MAXP];
  logic [REG_W-1:0] pRs   [MAXP];
  logic [REG_W-1:0] pRt   [MAXP];
  int progLen = 0;
  int decIdx = -1;
  int exIdx = -1;
  int memIdx = -1;

  always_comb begin
    idRs       = (decIdx >= 0) ? pRs[decIdx] : '0;
    idRt       = (decIdx >= 0) ? pRt[decIdx] : '0;
    idIsBranch = (decIdx >= 0) ? pBr[decIdx] : 1'b0;
    exMemRead  = (exIdx >= 0) ? pLoad[exIdx] : 1'b0;
    exRegWrite = (exIdx >= 0) ? pWr[exIdx] : 1'b0;
    exDest     = (exIdx >= 0) ? pDst[exIdx] : '0;
    memMemRead = (memIdx >= 0) ? pLoad[memIdx] : 1'b0;
    memDest    = (memIdx >= 0) ? pDst[memIdx] : '0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setInstr(input int i, input bit ld, input bit wr, input bit br,
                          input int dst, input int rs, input int rt);
    pLoad[i] = ld; pWr[i] = wr; pBr[i] = br;
    pDst[i] = dst[REG_W-1:0]; pRs[i] = rs[REG_W-1:0]; pRt[i] = rt[REG_W-1:0];
  endtask

  // Steps the pipeline model and counts stall cycles seen while instruction
  // `target` sits in decode; also checks enables against ctrlZero (R7).
  task automatic runProg(input int n, input int target, input int expStalls, input string req);
    int fetchIdx = 0;
    int stalls = 0;
    bit enOk = 1'b1;
    bit hold;
    progLen = n;
    decIdx = -1; exIdx = -1; memIdx = -1;
    for (int cyc = 0; cyc < n + 8; cyc++) begin
      @(negedge clk);
      hold = ctrlZero;
      if (pcWriteEn !== !ctrlZero || ifIdWriteEn !== !ctrlZero) enOk = 1'b0;
      if (decIdx == target && hold) stalls++;
      @(posedge clk);
      memIdx = exIdx;
      exIdx = hold ? -1 : decIdx;
      if (!hold) begin
        decIdx = (fetchIdx < n) ? fetchIdx : -1;
        fetchIdx++;
      end
    end
    decIdx = -1; exIdx = -1; memIdx = -1;
    check(stalls == expStalls, req, stalls, expStalls);
    check(enOk, {req, " R7 enables"}, int'(enOk), 1);
  endtask

  task automatic testIdle();
    decIdx = -1; exIdx = -1; memIdx = -1;
    @(negedge clk);
    check(ctrlZero == 1'b0 && pcWriteEn && ifIdWriteEn, "R8 idle", int'(ctrlZero), 0);
  endtask

  task automatic testLoadUse(); // R1, R9
    setInstr(0, 1, 1, 0, 3, 1, 0);
    setInstr(1, 0, 1, 0, 4, 2, 3);
    runProg(2, 1, 1, "R1 R9 load-use one stall");
  endtask

  task automatic testBranchAfterLoad(); // R3, R9
    setInstr(0, 1, 1, 0, 5, 1, 0);
    setInstr(1, 0, 0, 1, 0, 5, 6);
    runProg(2, 1, 2, "R3 R9 branch after load two stalls");
  endtask

  task automatic testBranchAfterAlu(); // R2
    setInstr(0, 0, 1, 0, 7, 1, 2);
    setInstr(1, 0, 0, 1, 0, 8, 7);
    runProg(2, 1, 1, "R2 branch after alu one stall");
  endtask

  task automatic testBranchLoadGap(); // R3
    setInstr(0, 1, 1, 0, 9, 1, 0);
    setInstr(1, 0, 0, 0, 0, 0, 0);
    setInstr(2, 0, 0, 1, 0, 9, 2);
    runProg(3, 2, 1, "R3 branch load two back one stall");
  endtask

  task automatic testBranchAluGap(); // R5
    setInstr(0, 0, 1, 0, 10, 1, 2);
    setInstr(1, 0, 0, 0, 0, 0, 0);
    setInstr(2, 0, 0, 1, 0, 10, 3);
    runProg(3, 2, 0, "R5 branch alu two back no stall");
  endtask

  task automatic testPlainLoadGap(); // R4
    setInstr(0, 1, 1, 0, 11, 1, 0);
    setInstr(1, 0, 0, 0, 0, 0, 0);
    setInstr(2, 0, 1, 0, 12, 11, 11);
    runProg(3, 2, 0, "R4 plain load two back no stall");
  endtask

  task automatic testRegZero(); // R6
    setInstr(0, 1, 1, 0, 0, 1, 0);
    setInstr(1, 0, 0, 1, 0, 0, 0);
    runProg(2, 1, 0, "R6 r0 load then branch no stall");
  endtask

  task automatic testPlainAfterAlu(); // R8
    setInstr(0, 0, 1, 0, 13, 1, 2);
    setInstr(1, 0, 1, 0, 14, 13, 13);
    runProg(2, 1, 0, "R8 alu then plain no stall");
  endtask

  initial begin
    testIdle();
    testLoadUse();
    testBranchAfterLoad();
    testBranchAfterAlu();
    testBranchLoadGap();
    testBranchAluGap();
    testPlainLoadGap();
    testRegZero();
    testPlainAfterAlu();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule